// File: doc/BRIEF.md
# Multi-Channel Countdown Timer with APB Access

This peripheral sits on an APB bus and holds eight countdown channels that run on their own. Each channel has a control word, a base value and a read-only view of its live count. A single `tick_en` input paces all channels. It stands in for a prescaled time base, so a channel steps once on every clock cycle where `tick_en` is high.

Software writes a base value, then writes the control word. Setting the update bit copies the base into the working count. Setting the start bit in the same write begins counting from that value. When a count runs out, the channel can flag itself in a shared status word that is cleared by writing ones. It can also drive its own interrupt line, either held until cleared or as a one-cycle strobe. After expiry the channel either reloads and keeps running, or halts and clears its own start bit.

Top module: `apb_cdtimer`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears the status word, every control word, base value and working count, and drives all eight `irq` lines low.
- R2: The status word is at byte address 0x000. Channel c has its control word at 0x010+0x10*c, its base value at +0x4 and its live count at +0xC. Every other address, including +0x8 in a channel window, 0x004 and anything from 0x090 up, reads 0. Writes to those addresses and to the live count have no effect. `pready` is always 1 and `pslverr` is always 0.
- R3: The control word stores bits 6:0 as written and reads bits 31:7 as 0. The bit meanings are: bit 1 start, bit 2 update, bit 4 auto-reload, bit 5 interrupt enable, bit 6 pulse mode (1) or level mode (0).
- R4: A control write with bit 2 set copies the base value into the working count. The live count reads the working count only while the start bit is 1, and reads 0 otherwise. A later write with only the start bit set resumes from the count already held.
- R5: A running channel drops its count by one on each cycle with `tick_en` high and holds it otherwise. Expiry happens on the tick that takes the count from 1 to 0. A channel loaded with 0 expires on its first tick.
- R6: On expiry with auto-reload set, the count is restored to the value copied at the last update and the channel keeps running.
- R7: On expiry with auto-reload clear, the channel clears its own start bit (control bit 1 reads 0) and its live count reads 0.
- R8: Status bit c is set on channel c's expiry only when interrupt enable is set. Writing 1 to status bit c clears that bit and lowers `irq[c]`. Bits written as 0 keep their value.
- R9: In level mode, `irq[c]` goes high in the cycle after expiry and stays high until status bit c is written with 1.
- R10: In pulse mode, `irq[c]` is high for exactly one clock cycle after expiry, while status bit c stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| paddr | input | 12 | APB byte address |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| tick_en | input | 1 | Count step enable shared by all channels |
| irq | output | 8 | One interrupt line per channel |

## Verification
The hardest behaviour to observe is what happens at and just after expiry. This includes the one-cycle strobe in pulse mode, the self-clearing start bit of a one-shot channel, a reload-from-zero channel that expires on every tick, and a status clear that names only some channels. The stimulus holds `tick_en` low during every bus access and raises it for an exact number of cycles. As a result, the bench knows the cycle in which each expiry lands. It then samples `irq` on the next falling edge and again one cycle later, and reads the status and control words back through the bus.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // control bit positions (decoded by the channel logic)
  localparam int CB_START = 1;
  localparam int CB_UPD   = 2;
  localparam int CB_AR    = 4;
  localparam int CB_IE    = 5;
  localparam int CB_PULSE = 6;

  // register offsets inside a channel window
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_BASE = 4'h4;
  localparam logic [3:0] OFS_CUR  = 4'hC;

  // a running channel expires when this tick leaves it at (or below) zero
  function automatic logic cnt_expires(input logic [63:0] c);
    return c <= 64'd1;
  endfunction

  // live count as seen on the bus: only while running
  function automatic logic [63:0] visible_count(input logic running, input logic [63:0] c);
    return running ? c : 64'd0;
  endfunction
endpackage

// File: rtl/cdt_chan.sv
module cdt_chan #(
  parameter int CNT_W  = 32,
  parameter int CTRL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_ctrl,
  input  logic              wr_base,
  input  logic [CTRL_W-1:0] wctrl,
  input  logic [CNT_W-1:0]  wbase,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CNT_W-1:0]  base_q,
  output logic [CNT_W-1:0]  cur_rd,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              expire,
  output logic              start,
  output logic              auto_rl,
  output logic              ie,
  output logic              pulse
);
  import cdt_pkg::*;

  logic [CNT_W-1:0] rl_q;
  logic             run_tick;

  assign start    = ctrl_q[CB_START];
  assign auto_rl  = ctrl_q[CB_AR];
  assign ie       = ctrl_q[CB_IE];
  assign pulse    = ctrl_q[CB_PULSE];
  // a bus write to control takes precedence over a tick in the same cycle
  assign run_tick = start && tick_en && !wr_ctrl;
  assign expire   = run_tick && cnt_expires(64'(cnt_q));
  assign cur_rd   = CNT_W'(visible_count(start, 64'(cnt_q)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      rl_q   <= '0;
    end else begin
      if (wr_base) base_q <= wbase;
      if (wr_ctrl) begin
        ctrl_q <= wctrl;
        if (wctrl[CB_UPD]) begin
          cnt_q <= base_q;
          rl_q  <= base_q;
        end
      end else if (run_tick) begin
        if (expire) begin
          if (auto_rl) begin
            cnt_q <= rl_q;
          end else begin
            cnt_q            <= '0;
            ctrl_q[CB_START] <= 1'b0;
          end
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_ev,
  input  logic [NUM_CH-1:0] pulse_sel,
  input  logic [NUM_CH-1:0] clr,
  output logic [NUM_CH-1:0] sts_q,
  output logic [NUM_CH-1:0] irq_q,
  output logic [NUM_CH-1:0] pls_q
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sts_q[g] <= 1'b0;
        irq_q[g] <= 1'b0;
        pls_q[g] <= 1'b0;
      end else begin
        // a new expiry wins over a clear landing in the same cycle
        if (set_ev[g])   sts_q[g] <= 1'b1;
        else if (clr[g]) sts_q[g] <= 1'b0;

        if (set_ev[g]) begin
          irq_q[g] <= 1'b1;
          pls_q[g] <= pulse_sel[g];
        end else if (clr[g] || pls_q[g]) begin
          irq_q[g] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cdt_apb_dec.sv
module cdt_apb_dec #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int CTRL_W = 7
) (
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [NUM_CH-1:0][CTRL_W-1:0] rd_ctrl,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_base,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  rd_cur,
  input  logic [NUM_CH-1:0]            rd_sts,
  output logic [NUM_CH-1:0]            wr_ctrl,
  output logic [NUM_CH-1:0]            wr_base,
  output logic                         wr_sts,
  output logic [DATA_W-1:0]            prdata
);
  import cdt_pkg::*;

  localparam int IDX_W = ADDR_W - 4;
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'((NUM_CH + 1) * 16);

  logic             wr_acc;
  logic             in_win;
  logic [IDX_W-1:0] ch_idx;
  logic [3:0]       ofs;

  assign wr_acc = psel && penable && pwrite;
  assign in_win = (paddr >= WIN_LO) && (paddr < WIN_HI);
  assign ch_idx = paddr[ADDR_W-1:4] - IDX_W'(1);
  assign ofs    = paddr[3:0];
  assign wr_sts = wr_acc && (paddr == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wdec
    assign wr_ctrl[g] = wr_acc && in_win && (ch_idx == IDX_W'(g)) && (ofs == OFS_CTRL);
    assign wr_base[g] = wr_acc && in_win && (ch_idx == IDX_W'(g)) && (ofs == OFS_BASE);
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (paddr == '0) begin
        prdata = DATA_W'(rd_sts);
      end else if (in_win) begin
        for (int k = 0; k < NUM_CH; k++) begin
          if (ch_idx == IDX_W'(k)) begin
            case (ofs)
              OFS_CTRL: prdata = DATA_W'(rd_ctrl[k]);
              OFS_BASE: prdata = DATA_W'(rd_base[k]);
              OFS_CUR:  prdata = DATA_W'(rd_cur[k]);
              default:  prdata = '0;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/apb_cdtimer.sv
module apb_cdtimer #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int CTRL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              tick_en,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0][CTRL_W-1:0] ch_ctrl;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_base;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cur;
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
  logic [NUM_CH-1:0]             ch_expire;
  logic [NUM_CH-1:0]             ch_start;
  logic [NUM_CH-1:0]             ch_ar;
  logic [NUM_CH-1:0]             ch_ie;
  logic [NUM_CH-1:0]             ch_pulse;
  logic [NUM_CH-1:0]             ch_wr_ctrl;
  logic [NUM_CH-1:0]             ch_wr_base;
  logic                          sts_wr;
  logic [NUM_CH-1:0]             sts_clr;
  logic [NUM_CH-1:0]             sts_q;
  logic [NUM_CH-1:0]             irq_set;
  logic [NUM_CH-1:0]             pls_hold;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign sts_clr = sts_wr ? pwdata[NUM_CH-1:0] : '0;
  assign irq_set = ch_expire & ch_ie;

  cdt_apb_dec #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CTRL_W(CTRL_W)
  ) u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .rd_ctrl (ch_ctrl),
    .rd_base (ch_base),
    .rd_cur  (ch_cur),
    .rd_sts  (sts_q),
    .wr_ctrl (ch_wr_ctrl),
    .wr_base (ch_wr_base),
    .wr_sts  (sts_wr),
    .prdata  (prdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    cdt_chan #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_ctrl (ch_wr_ctrl[g]),
      .wr_base (ch_wr_base[g]),
      .wctrl   (pwdata[CTRL_W-1:0]),
      .wbase   (pwdata[CNT_W-1:0]),
      .ctrl_q  (ch_ctrl[g]),
      .base_q  (ch_base[g]),
      .cur_rd  (ch_cur[g]),
      .cnt_q   (ch_cnt[g]),
      .expire  (ch_expire[g]),
      .start   (ch_start[g]),
      .auto_rl (ch_ar[g]),
      .ie      (ch_ie[g]),
      .pulse   (ch_pulse[g])
    );
  end

  cdt_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_ev    (irq_set),
    .pulse_sel (ch_pulse),
    .clr       (sts_clr),
    .sts_q     (sts_q),
    .irq_q     (irq),
    .pls_q     (pls_hold)
  );
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tick_en,
  input logic                        pready,
  input logic                        pslverr,
  input logic [NUM_CH-1:0]           irq,
  input logic [NUM_CH-1:0]           sts,
  input logic [NUM_CH-1:0]           clr,
  input logic [NUM_CH-1:0]           expire,
  input logic [NUM_CH-1:0]           ie,
  input logic [NUM_CH-1:0]           ar,
  input logic [NUM_CH-1:0]           start,
  input logic [NUM_CH-1:0]           pls_hold,
  input logic [NUM_CH-1:0]           wr_ctrl,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);
  // R1: one reset edge leaves every line and status bit low
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq == '0 && sts == '0));

  // R2: the bus never stalls or errors
  a_r2_bus_ok: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R5: no tick and no control write keeps the count
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en && !wr_ctrl[g] |=> $stable(cnt[g]));

    // R7: one-shot expiry stops the channel
    a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] && !ar[g] |=> !start[g]);

    // R8: enabled expiry flags status and raises the line
    a_r8_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] && ie[g] |=> sts[g] && irq[g]);

    // R9: a level line stays up until cleared
    a_r9_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] && !pls_hold[g] && !clr[g] |=> irq[g]);

    // R10: a pulse line drops after one cycle unless re-fired
    a_r10_pulse_drops: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] && pls_hold[g] && !(expire[g] && ie[g]) |=> !irq[g]);
  end
endmodule

bind apb_cdtimer cdt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .pready   (pready),
  .pslverr  (pslverr),
  .irq      (irq),
  .sts      (sts_q),
  .clr      (sts_clr),
  .expire   (ch_expire),
  .ie       (ch_ie),
  .ar       (ch_ar),
  .start    (ch_start),
  .pls_hold (pls_hold),
  .wr_ctrl  (ch_wr_ctrl),
  .cnt      (ch_cnt)
);

// File: tb/apb_cdtimer_tb.sv
module apb_cdtimer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] paddr = '0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic        pslverr;
  logic        tick_en = 1'b0;
  logic [7:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  apb_cdtimer u_dut (
    .clk(clk), .rst_n(rst_n), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .tick_en(tick_en), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  ch;
    logic [31:0] base;
    logic [7:0]  ctrl;
    logic [7:0]  ticks;
    logic [31:0] exp_cnt;
    logic        exp_sts;
    logic [7:0]  exp_ctrl;
  } vec_t;

  // ctrl: 0x02 start, 0x04 update, 0x10 auto-reload, 0x20 irq enable, 0x40 pulse
  localparam vec_t VECS [6] = '{
    '{3'd0, 32'd10,    8'h06, 8'd3, 32'd7,   1'b0, 8'h06},  // R5 plain count down
    '{3'd1, 32'd4,     8'h26, 8'd4, 32'd0,   1'b1, 8'h24},  // R7 one-shot stops
    '{3'd2, 32'd3,     8'h36, 8'd5, 32'd1,   1'b1, 8'h36},  // R6 reload then continue
    '{3'd3, 32'd0,     8'h16, 8'd2, 32'd0,   1'b0, 8'h16},  // R5 zero load, no irq enable (R8)
    '{3'd7, 32'h100,   8'h06, 8'd0, 32'h100, 1'b0, 8'h06},  // R4 last window
    '{3'd5, 32'd2,     8'h66, 8'd2, 32'd0,   1'b1, 8'h64}   // R10 pulse one-shot
  };

  function automatic logic [11:0] ch_addr(input int c, input int ofs);
    return 12'(16 + 16 * c + ofs);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // called at a falling edge; returns at the falling edge after the last tick
  task automatic ticks(input int n);
    if (n > 0) begin
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    apb_rd(12'h000, d); check("R1 status", d, 32'h0);
    apb_rd(ch_addr(0, 0), d); check("R1 ctrl ch0", d, 32'h0);
    apb_rd(ch_addr(7, 4), d); check("R1 base ch7", d, 32'h0);
    apb_rd(ch_addr(3, 12), d); check("R1 count ch3", d, 32'h0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      int c;
      c = int'(VECS[v].ch);
      apb_wr(ch_addr(c, 4), VECS[v].base);
      apb_wr(ch_addr(c, 0), 32'(VECS[v].ctrl));
      ticks(int'(VECS[v].ticks));
      apb_rd(ch_addr(c, 12), d); check("R5/R6/R7 count", d, VECS[v].exp_cnt);
      apb_rd(12'h000, d);        check("R8 status bit", 32'(d[c]), 32'(VECS[v].exp_sts));
      apb_rd(ch_addr(c, 0), d);  check("R3/R7 ctrl", d, 32'(VECS[v].exp_ctrl));
      apb_wr(ch_addr(c, 0), 32'h0);
      apb_wr(12'h000, 32'hFF);
    end

    // R3 upper control bits dropped
    apb_wr(ch_addr(2, 0), 32'hFFFF_FF90);
    apb_rd(ch_addr(2, 0), d); check("R3 ctrl readback", d, 32'h10);
    apb_wr(ch_addr(2, 0), 32'h0);

    // R4 update without start, then start alone
    apb_wr(ch_addr(0, 4), 32'd9);
    apb_wr(ch_addr(0, 0), 32'h04);
    apb_rd(ch_addr(0, 12), d); check("R4 stopped reads 0", d, 32'h0);
    ticks(2);
    apb_wr(ch_addr(0, 0), 32'h02);
    apb_rd(ch_addr(0, 12), d); check("R4 resume loaded", d, 32'd9);
    ticks(1);
    apb_rd(ch_addr(0, 12), d); check("R5 one tick", d, 32'd8);

    // R2 unmapped and read-only addresses
    apb_rd(12'h008, d); check("R2 hole 0x008", d, 32'h0);
    apb_rd(12'h018, d); check("R2 hole +8", d, 32'h0);
    apb_wr(12'h01C, 32'h55);
    apb_wr(12'h004, 32'hFF);
    apb_wr(12'h090, 32'hFF);
    apb_rd(ch_addr(0, 12), d); check("R2 count write ignored", d, 32'd8);
    apb_rd(12'h090, d); check("R2 beyond windows", d, 32'h0);
    apb_rd(12'h004, d); check("R2 hole 0x004", d, 32'h0);
    check("R2 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
    apb_wr(ch_addr(0, 0), 32'h0);

    // R9 level interrupt and partial clear (R8)
    apb_wr(ch_addr(4, 4), 32'd1);
    apb_wr(ch_addr(4, 0), 32'h26);
    ticks(1);
    check("R9 level raised", 32'(irq[4]), 32'h1);
    repeat (3) @(negedge clk);
    check("R9 level held", 32'(irq[4]), 32'h1);
    apb_wr(12'h000, 32'h01);
    check("R8 zero bits keep irq", 32'(irq[4]), 32'h1);
    apb_rd(12'h000, d); check("R8 zero bits keep status", d, 32'h10);
    apb_wr(12'h000, 32'h10);
    check("R9 cleared", 32'(irq[4]), 32'h0);
    apb_rd(12'h000, d); check("R8 status cleared", d, 32'h0);

    // R10 pulse interrupt
    apb_wr(ch_addr(6, 4), 32'd1);
    apb_wr(ch_addr(6, 0), 32'h66);
    ticks(1);
    check("R10 pulse high", 32'(irq[6]), 32'h1);
    @(negedge clk);
    check("R10 pulse low", 32'(irq[6]), 32'h0);
    apb_rd(12'h000, d); check("R10 status stays", d, 32'h40);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule